// File: doc/BRIEF.md
# Partitioned SIMD Lane ALU

This unit treats each 32-bit operand word as a vector of independent integer lanes. Software selects the lane width for every transfer: four 8-bit lanes, two 16-bit lanes, one 32-bit lane, or a guard mode. Guard mode packs four 7-bit values into one word and keeps one spare guard bit above each value. Each lane has its own carry and borrow chain, so one lane's arithmetic never disturbs its neighbour. The unit supports bitwise logic, wrapping add and subtract, equality and unsigned greater-than compares, unsigned maximum and unsigned absolute difference.

Operands enter through a valid/ready stream, and results leave through a second valid/ready stream, one register stage later. The input side is ready when the output register is empty or when its content is being taken in the same cycle. While the output is valid and the consumer holds ready low, the result and its error flag stay frozen and no new operand pair is accepted. Operation and lane-mode codes that do not form a supported pair still produce a result beat. That beat carries an all-zero result and a raised error flag.

Top module: `simd_lane_alu`

## Requirements
- R1: While reset is asserted, out_valid, out_data and out_err are all 0.
- R2: AND (op 0), OR (op 1) and XOR (op 2) give the plain 32-bit bitwise result in every lane mode (lane 0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = guard).
- R3: ADD (op 3) wraps within each lane at 8, 16 and 32 bits, with no carry into the next lane. In 8-bit mode the result equals ((a & 0x7f7f7f7f) + (b & 0x7f7f7f7f)) ^ ((a ^ b) & 0x80808080).
- R4: SUB (op 4) wraps within each lane at 8, 16 and 32 bits, with no borrow into the next lane.
- R5: In guard mode, ADD returns (a + b) & 0x7f7f7f7f. The value sits in bits 6:0 of each byte, and bit 7 of each byte is the guard bit.
- R6: In guard mode, SUB returns ((a | 0x80808080) - (b & 0x7f7f7f7f)) & 0x7f7f7f7f.
- R7: EQ (op 5) and unsigned GT (op 6) fill each 8-, 16- or 32-bit lane with all ones when the condition holds and with all zeros when it fails.
- R8: Unsigned MAX (op 7) works in 8- and 16-bit mode. Unsigned absolute difference (op 8) works in 8-bit mode.
- R9: Any other pairing of op and lane mode gives out_data 0 with out_err 1 on that beat. This covers compares in guard mode, MAX in 32-bit or guard mode, absolute difference outside 8-bit mode, and op codes 9 to 15.
- R10: An accepted transfer appears on the output one clock later. in_ready equals !out_valid || out_ready. While out_valid is high and out_ready is low, out_data and out_err hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand pair offered |
| in_ready | output | 1 | Unit can accept an operand pair |
| in_a | input | 32 | First operand (minuend) |
| in_b | input | 32 | Second operand (subtrahend) |
| in_op | input | 4 | Operation code |
| in_lane | input | 2 | Lane mode |
| out_valid | output | 1 | Result beat present |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 32 | Lane-wise result |
| out_err | output | 1 | Unsupported op/lane pairing on this beat |

## Verification
Every result and its error flag become visible exactly one rising edge after the edge that accepts the operands. Each test drives its inputs on a falling edge and samples out_data, out_err and out_valid on the next falling edge, so the sample lands midway after the single register stage. The back-pressure test looks at in_ready half a cycle after the stall begins. It then checks that the stalled output has not changed a full cycle later, and it reads the queued result one edge after out_ready returns high.

// File: rtl/simd_pkg.sv
package simd_pkg;
  localparam int WORD_W = 32;
  localparam int SEG_W  = 8;

  typedef enum logic [3:0] {
    OP_AND  = 4'd0,
    OP_OR   = 4'd1,
    OP_XOR  = 4'd2,
    OP_ADD  = 4'd3,
    OP_SUB  = 4'd4,
    OP_EQ   = 4'd5,
    OP_GT   = 4'd6,
    OP_MAX  = 4'd7,
    OP_ABSD = 4'd8
  } simd_op_e;

  typedef enum logic [1:0] {
    LN_8     = 2'd0,
    LN_16    = 2'd1,
    LN_32    = 2'd2,
    LN_GUARD = 2'd3
  } simd_lane_e;
endpackage

// File: rtl/simd_addsub.sv
module simd_addsub
  import simd_pkg::*;
#(
  parameter int W  = WORD_W,
  parameter int SW = SEG_W
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  input  logic [1:0]   lane,
  output logic [W-1:0] y
);
  localparam int NSEG = W / SW;

  logic [W-1:0]  guard_bits;
  logic [W-1:0]  opa, opb, opb_x, sum;
  logic [NSEG:0] carry;
  logic          guard;

  assign guard = (lane == LN_GUARD);

  // one guard bit at the top of every segment
  for (genvar g = 0; g < NSEG; g++) begin : g_mask
    assign guard_bits[g*SW +: SW] = {1'b1, {(SW-1){1'b0}}};
  end

  assign opa   = (guard && sub) ? (a | guard_bits) : a;
  assign opb   = (guard && sub) ? (b & ~guard_bits) : b;
  assign opb_x = sub ? ~opb : opb;
  assign carry[0] = sub;

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    logic          cut, cin;
    logic [SW:0]   part;
    if (s == 0) begin : g_first
      assign cut = 1'b1;
    end else begin : g_rest
      assign cut = (lane == LN_8) || ((lane == LN_16) && (s % 2 == 0));
    end
    assign cin  = cut ? sub : carry[s];
    assign part = {1'b0, opa[s*SW +: SW]} + {1'b0, opb_x[s*SW +: SW]} + {{SW{1'b0}}, cin};
    assign sum[s*SW +: SW] = part[SW-1:0];
    assign carry[s+1]      = part[SW];
  end

  assign y = guard ? (sum & ~guard_bits) : sum;
endmodule

// File: rtl/simd_lane_cmp.sv
module simd_lane_cmp
  import simd_pkg::*;
#(
  parameter int W  = WORD_W,
  parameter int LW = SEG_W
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] eq_m,
  output logic [W-1:0] gt_m
);
  localparam int NL = W / LW;

  for (genvar l = 0; l < NL; l++) begin : g_lane
    logic hit_eq, hit_gt;
    assign hit_eq = (a[l*LW +: LW] == b[l*LW +: LW]);
    assign hit_gt = (a[l*LW +: LW] >  b[l*LW +: LW]);
    assign eq_m[l*LW +: LW] = {LW{hit_eq}};
    assign gt_m[l*LW +: LW] = {LW{hit_gt}};
  end
endmodule

// File: rtl/simd_lane_alu.sv
module simd_lane_alu
  import simd_pkg::*;
#(
  parameter int W  = WORD_W,
  parameter int SW = SEG_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  input  logic [3:0]   in_op,
  input  logic [1:0]   in_lane,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data,
  output logic         out_err
);
  localparam int NSEG = W / SW;
  localparam int NW   = 4;

  logic [W-1:0] as_y;
  logic [W-1:0] eq_w [NW];
  logic [W-1:0] gt_w [NW];
  logic [W-1:0] absd8;
  logic [W-1:0] res;
  logic         err;

  simd_addsub #(.W(W), .SW(SW)) u_addsub (
    .a    (in_a),
    .b    (in_b),
    .sub  (in_op == OP_SUB),
    .lane (in_lane),
    .y    (as_y)
  );

  // compare banks for 8/16/32-bit lanes; slot 3 (guard) has none
  for (genvar g = 0; g < NW; g++) begin : g_cmp
    if (g < 3) begin : g_bank
      simd_lane_cmp #(.W(W), .LW(SW << g)) u_cmp (
        .a    (in_a),
        .b    (in_b),
        .eq_m (eq_w[g]),
        .gt_m (gt_w[g])
      );
    end else begin : g_none
      assign eq_w[g] = '0;
      assign gt_w[g] = '0;
    end
  end

  for (genvar s = 0; s < NSEG; s++) begin : g_absd
    logic [SW-1:0] xa, xb;
    assign xa = in_a[s*SW +: SW];
    assign xb = in_b[s*SW +: SW];
    assign absd8[s*SW +: SW] = gt_w[0][s*SW] ? (xa - xb) : (xb - xa);
  end

  always_comb begin
    res = '0;
    err = 1'b0;
    case (in_op)
      OP_AND: res = in_a & in_b;
      OP_OR:  res = in_a | in_b;
      OP_XOR: res = in_a ^ in_b;
      OP_ADD, OP_SUB: res = as_y;
      OP_EQ, OP_GT: begin
        if (in_lane == LN_GUARD) err = 1'b1;
        else res = (in_op == OP_EQ) ? eq_w[in_lane] : gt_w[in_lane];
      end
      OP_MAX: begin
        if (in_lane == LN_8 || in_lane == LN_16)
          res = (gt_w[in_lane] & in_a) | (~gt_w[in_lane] & in_b);
        else err = 1'b1;
      end
      OP_ABSD: begin
        if (in_lane == LN_8) res = absd8;
        else err = 1'b1;
      end
      default: err = 1'b1;
    endcase
  end

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_err   <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_data <= res;
        out_err  <= err;
      end
    end
  end
endmodule

// File: rtl/simd_lane_alu_chk.sv
module simd_lane_alu_chk
  import simd_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic [31:0] in_a,
  input logic [31:0] in_b,
  input logic [3:0]  in_op,
  input logic [1:0]  in_lane,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] out_data,
  input logic        out_err
);
  logic acc;
  assign acc = in_valid && in_ready;

  function automatic logic bytes_uniform(input logic [31:0] v);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < 4; i++)
      if (v[i*8 +: 8] != 8'h00 && v[i*8 +: 8] != 8'hFF) ok = 1'b0;
    return ok;
  endfunction

  assert_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_err)));

  assert_err_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_err) |-> (out_data == 32'h0));

  assert_guard_add_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_op == OP_ADD && in_lane == LN_GUARD) |=> ((out_data & 32'h80808080) == 32'h0));

  assert_guard_sub_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_op == OP_SUB && in_lane == LN_GUARD) |=> ((out_data & 32'h80808080) == 32'h0));

  assert_cmp_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (in_op == OP_EQ || in_op == OP_GT) && in_lane == LN_8) |=> bytes_uniform(out_data));

  assert_and_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_op == OP_AND) |=> (out_data == ($past(in_a) & $past(in_b)) && !out_err));
endmodule

bind simd_lane_alu simd_lane_alu_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_a      (in_a),
  .in_b      (in_b),
  .in_op     (in_op),
  .in_lane   (in_lane),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_err   (out_err)
);

// File: tb/simd_lane_alu_tb.sv
`timescale 1ns/1ps
module simd_lane_alu_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_a = '0, in_b = '0;
  logic [3:0]  in_op = '0;
  logic [1:0]  in_lane = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_data;
  logic        out_err;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  simd_lane_alu u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_op(in_op), .in_lane(in_lane),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_err(out_err)
  );

  // {op, lane, a, b, expected, err}
  localparam int NV = 25;
  localparam logic [102:0] VEC [NV] = '{
    {4'd0, 2'd0, 32'hF0F01234, 32'h0FF0FF00, 32'h00F01200, 1'b0},
    {4'd1, 2'd2, 32'hF0F01234, 32'h0FF0FF00, 32'hFFF0FF34, 1'b0},
    {4'd2, 2'd3, 32'hF0F01234, 32'h0FF0FF00, 32'hFF00ED34, 1'b0},
    {4'd3, 2'd0, 32'hFF01807F, 32'h01028001, 32'h00030080, 1'b0},
    {4'd3, 2'd1, 32'h00FFFFFF, 32'h00010001, 32'h01000000, 1'b0},
    {4'd3, 2'd2, 32'h00FFFFFF, 32'h00000001, 32'h01000000, 1'b0},
    {4'd4, 2'd0, 32'h00100005, 32'h01010106, 32'hFF0FFFFF, 1'b0},
    {4'd4, 2'd1, 32'h00000005, 32'h00010006, 32'hFFFFFFFF, 1'b0},
    {4'd4, 2'd2, 32'h00010000, 32'h00000001, 32'h0000FFFF, 1'b0},
    {4'd3, 2'd3, 32'h7F014040, 32'h01014040, 32'h00020000, 1'b0},
    {4'd4, 2'd3, 32'h00050010, 32'h01060001, 32'h7F7F000F, 1'b0},
    {4'd5, 2'd0, 32'h11223344, 32'h11220044, 32'hFFFF00FF, 1'b0},
    {4'd5, 2'd1, 32'h11223344, 32'h11220044, 32'hFFFF0000, 1'b0},
    {4'd5, 2'd2, 32'h11223344, 32'h11220044, 32'h00000000, 1'b0},
    {4'd6, 2'd0, 32'h80017F00, 32'h7F027F00, 32'hFF000000, 1'b0},
    {4'd6, 2'd1, 32'h00018000, 32'h00007FFF, 32'hFFFFFFFF, 1'b0},
    {4'd6, 2'd2, 32'h00010000, 32'h0000FFFF, 32'hFFFFFFFF, 1'b0},
    {4'd7, 2'd0, 32'h10F00180, 32'h2080017F, 32'h20F00180, 1'b0},
    {4'd7, 2'd1, 32'h01008000, 32'h00FF8001, 32'h01008001, 1'b0},
    {4'd8, 2'd0, 32'h0510FF00, 32'h100500FF, 32'h0B0BFFFF, 1'b0},
    {4'd7, 2'd2, 32'h12345678, 32'h00000001, 32'h00000000, 1'b1},
    {4'd8, 2'd1, 32'h12345678, 32'h00000001, 32'h00000000, 1'b1},
    {4'd5, 2'd3, 32'h12345678, 32'h12345678, 32'h00000000, 1'b1},
    {4'd15, 2'd0, 32'h12345678, 32'h00000001, 32'h00000000, 1'b1},
    {4'd8, 2'd3, 32'h12345678, 32'h00000001, 32'h00000000, 1'b1}
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic string tag_of(input logic [3:0] op, input logic [1:0] ln, input logic e);
    if (e) return "R9";
    if (op < 4'd3) return "R2";
    if (op == 4'd3) return (ln == 2'd3) ? "R5" : "R3";
    if (op == 4'd4) return (ln == 2'd3) ? "R6" : "R4";
    if (op == 4'd5 || op == 4'd6) return "R7";
    return "R8";
  endfunction

  task automatic apply(input logic [3:0] op, input logic [1:0] ln, input logic [31:0] a,
                       input logic [31:0] b, output logic [31:0] d, output logic e,
                       output logic v);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_lane = ln; in_a = a; in_b = b;
    @(negedge clk);
    d = out_data; e = out_err; v = out_valid;
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, exp;
    logic e, v;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 valid", {31'd0, out_valid}, 32'd0);
    check("R1 data", out_data, 32'd0);
    check("R1 err", {31'd0, out_err}, 32'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][102:99], VEC[i][98:97], VEC[i][96:65], VEC[i][64:33], d, e, v);
      check({tag_of(VEC[i][102:99], VEC[i][98:97], VEC[i][0]), " data"}, d, VEC[i][32:1]);
      check({tag_of(VEC[i][102:99], VEC[i][98:97], VEC[i][0]), " err"}, {31'd0, e}, {31'd0, VEC[i][0]});
      check("R10 valid", {31'd0, v}, 32'd1);
    end

    // R3: 8-bit add against the masked-carry expression
    for (int k = 0; k < 6; k++) begin
      logic [31:0] a, b;
      a = 32'h9E3779B9 * (k + 1);
      b = {a[15:0], a[31:16]} ^ 32'hA5A55A5A;
      exp = ((a & 32'h7f7f7f7f) + (b & 32'h7f7f7f7f)) ^ ((a ^ b) & 32'h80808080);
      apply(4'd3, 2'd0, a, b, d, e, v);
      check("R3 mask form", d, exp);
    end

    // R10: back-pressure holds result and blocks input
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_op = 4'd2; in_lane = 2'd0; in_a = 32'h0000FFFF; in_b = 32'h00FF00FF;
    @(negedge clk);
    in_op = 4'd1; in_a = 32'h12000000; in_b = 32'h00000034;
    check("R10 ready low", {31'd0, in_ready}, 32'd0);
    check("R10 first", out_data, 32'h00FFFF00);
    @(negedge clk);
    check("R10 hold", out_data, 32'h00FFFF00);
    check("R10 hold valid", {31'd0, out_valid}, 32'd1);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R10 second", out_data, 32'h12000034);
    @(negedge clk);
    check("R10 drain", {31'd0, out_valid}, 32'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule